// File: doc/BRIEF.md
# Serial Flash Read Output Engine

This block is the outbound data path of a serial flash slave. A command front end decodes the opcode and gathers the 24-bit start address. It then hands the request to this engine with a single-cycle start strobe. From that point the engine drives the output pins until chip select rises. It supports four request kinds: a plain array read with no wait byte; a fast read that idles the pins for one dummy byte; a dual-output fast read; and a status read that repeats the status byte.

In the dual-output form, both serial pins become outputs after the dummy byte, so one array byte leaves every four serial clocks. Array bytes come from a synchronous read port, one byte per request. The engine issues each request on the rising edge that opens the byte's first bit slot, and it advances the address on its own, wrapping at the top of the 24-bit space. Output bits change on the falling serial clock edge, so the master samples stable data on the rising edge. A request that arrives while the array is busy is dropped.

Top module: `flash_rd_engine`

## Requirements
- R1: Plain read (mode 0): the bit-7 of the byte at the start address appears on `so_o` on the first falling edge after the rising edge that sampled `start_i`. The following bits come out most significant bit first, one per clock, with no dummy slots.
- R2: Fast read (mode 1): `so_oe_o` stays low for the first 8 falling edges after the start. The array data then follows as in R1, starting at the start address.
- R3: Dual read (mode 2): after 8 dummy clocks with both pins tri-stated, each byte takes 4 clocks. `so_o` carries bits 7, 5, 3, 1 and `sio_o` carries bits 6, 4, 2, 0, in that order. `sio_oe_o` is high only in this mode's data phase.
- R4: Data output continues across byte boundaries without a gap. The address advances by one per byte for as long as `cs_n` stays low.
- R5: The byte address wraps from FFFFFFh to 000000h.
- R6: Status read (mode 3): `status_i` is shifted out MSB first and repeats every 8 clocks. No array read is issued.
- R7: When `cs_n` rises, both output enables drop at once, whatever bit the stream is on. The engine goes idle and issues no further array reads.
- R8: A start strobe sampled while `busy_i` is high is ignored. The outputs stay tri-stated and no array read is issued.
- R9: After reset, both output enables are low and `mem_rd_o` is low.
- R10: The engine asserts `mem_rd_o` once per array byte. A plain read issues its first read on the start edge. For a fast or dual read, the first read falls on the edge that ends the dummy byte. Each later read falls on the edge that begins that byte's first bit slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| start_i | input | 1 | One-cycle request strobe from the command front end |
| mode_i | input | 2 | 0 plain, 1 fast, 2 dual, 3 status |
| addr_i | input | 24 | Start byte address |
| busy_i | input | 1 | Array busy with a write or erase |
| status_i | input | 8 | Status byte to repeat |
| mem_rd_o | output | 1 | Array read request |
| mem_addr_o | output | 24 | Array read address |
| mem_data_i | input | 8 | Array read data, valid after the requesting edge |
| so_o | output | 1 | Primary serial output data |
| so_oe_o | output | 1 | Primary output enable |
| sio_o | output | 1 | Second data line output in dual mode |
| sio_oe_o | output | 1 | Second line output enable |

## Verification
A request sampled on rising edge 0 puts the bit for slot t on the pins at the falling edge that follows rising edge t. The bench therefore reads slot t 1 ns after rising edge t+1, which is half a clock clear of the edge that changes it. Each expectation comes from the slot index alone: 8 dummy slots for fast and dual requests, then 8 or 4 slots per byte. The address to fetch is the start address plus the byte count, taken modulo 2^24. The drop on chip-select rise is combinational and is checked 1 ns after the rise. Array reads are counted on each rising edge and compared with one read per byte started.

// File: rtl/flash_rd_pkg.sv
`timescale 1ns/1ps
package flash_rd_pkg;
  localparam int BYTE_W = 8;
  localparam int SLOT_W = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    RM_PLAIN  = 2'd0,
    RM_FAST   = 2'd1,
    RM_DUAL   = 2'd2,
    RM_STATUS = 2'd3
  } rd_mode_e;

  // Final slot of the current byte: dual data bytes use 4 slots, all else 8.
  function automatic logic [SLOT_W-1:0] final_slot(rd_mode_e m, logic dmy);
    return (m == RM_DUAL && !dmy) ? SLOT_W'(BYTE_W/2 - 1) : SLOT_W'(BYTE_W - 1);
  endfunction

  function automatic logic needs_dummy(rd_mode_e m);
    return (m == RM_FAST) || (m == RM_DUAL);
  endfunction
endpackage

// File: rtl/frd_slot_seq.sv
`timescale 1ns/1ps
module frd_slot_seq
  import flash_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              start_i,
  input  logic              busy_i,
  input  rd_mode_e          mode_i,
  output logic              accept_o,
  output logic              active_o,
  output rd_mode_e          mode_o,
  output logic              dummy_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              byte_end_o
);
  assign accept_o   = start_i & ~busy_i & ~cs_n;
  assign byte_end_o = active_o & (slot_o == final_slot(mode_o, dummy_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      mode_o   <= RM_PLAIN;
      dummy_o  <= 1'b0;
      slot_o   <= '0;
    end else if (cs_n) begin
      active_o <= 1'b0;
      dummy_o  <= 1'b0;
      slot_o   <= '0;
    end else if (accept_o) begin
      active_o <= 1'b1;
      mode_o   <= mode_i;
      dummy_o  <= needs_dummy(mode_i);
      slot_o   <= '0;
    end else if (active_o) begin
      if (byte_end_o) begin
        slot_o  <= '0;
        dummy_o <= 1'b0;
      end else begin
        slot_o <= slot_o + SLOT_W'(1);
      end
    end
  end

  p_cs_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !active_o);
  p_busy_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_i && !active_o) |=> !active_o);
endmodule

// File: rtl/frd_addr_gen.sv
`timescale 1ns/1ps
module frd_addr_gen
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 24
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              accept_i,
  input  rd_mode_e          mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  rd_mode_e          mode_r_i,
  input  logic              byte_end_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o
);
  logic [ADDR_W-1:0] next_q;
  logic              fetch_now, fetch_next;

  // Natural modulo-2^ADDR_W step: the top address rolls to zero.
  function automatic logic [ADDR_W-1:0] step_addr(logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  assign fetch_now  = accept_i & (mode_i == RM_PLAIN);
  assign fetch_next = byte_end_i & ~cs_n & ~accept_i & (mode_r_i != RM_STATUS);
  assign mem_rd_o   = fetch_now | fetch_next;
  assign mem_addr_o = accept_i ? addr_i : next_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          next_q <= '0;
    else if (accept_i)   next_q <= fetch_now ? step_addr(addr_i) : addr_i;
    else if (fetch_next) next_q <= step_addr(next_q);
  end
endmodule

// File: rtl/frd_out_drv.sv
`timescale 1ns/1ps
module frd_out_drv
  import flash_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              active_i,
  input  rd_mode_e          mode_i,
  input  logic              dummy_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [BYTE_W-1:0] mem_data_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              sio_o,
  output logic              sio_oe_o
);
  logic [BYTE_W-1:0] hold_q, src;
  logic [SLOT_W-1:0] so_idx, sio_idx;
  logic              so_en_q, sio_en_q, data_ph;

  function automatic logic [SLOT_W-1:0] hi_index(logic [SLOT_W-1:0] s, logic dual);
    return dual ? SLOT_W'(BYTE_W-1) - {s[SLOT_W-2:0], 1'b0} : SLOT_W'(BYTE_W-1) - s;
  endfunction

  assign data_ph = active_i & ~dummy_i;
  assign src     = (mode_i == RM_STATUS) ? status_i :
                   (slot_i == '0)        ? mem_data_i : hold_q;
  assign so_idx  = hi_index(slot_i, mode_i == RM_DUAL);
  assign sio_idx = so_idx - SLOT_W'(1);

  // Fresh array byte is on mem_data_i during slot 0; keep it for the rest.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (data_ph && slot_i == '0 && mode_i != RM_STATUS) hold_q <= mem_data_i;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so_o <= 1'b0; sio_o <= 1'b0; so_en_q <= 1'b0; sio_en_q <= 1'b0;
    end else begin
      so_o     <= src[so_idx];
      sio_o    <= src[sio_idx];
      so_en_q  <= data_ph & ~cs_n;
      sio_en_q <= data_ph & ~cs_n & (mode_i == RM_DUAL);
    end
  end

  assign so_oe_o  = so_en_q & ~cs_n;
  assign sio_oe_o = sio_en_q & ~cs_n;

  p_dual_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sio_oe_o |-> so_oe_o);
  p_dummy_quiet_r2: assert property (@(negedge clk) disable iff (!rst_n)
    (active_i && dummy_i) |=> !so_oe_o);
endmodule

// File: rtl/flash_rd_engine.sv
`timescale 1ns/1ps
module flash_rd_engine
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 24
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [BYTE_W-1:0] mem_data_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              sio_o,
  output logic              sio_oe_o
);
  rd_mode_e          req_mode, cur_mode;
  logic              accept_w, active_w, dummy_w, byte_end_w;
  logic [SLOT_W-1:0] slot_w;

  assign req_mode = rd_mode_e'(mode_i);

  frd_slot_seq u_seq (
    .clk, .rst_n, .cs_n, .start_i, .busy_i, .mode_i(req_mode),
    .accept_o(accept_w), .active_o(active_w), .mode_o(cur_mode),
    .dummy_o(dummy_w), .slot_o(slot_w), .byte_end_o(byte_end_w)
  );

  frd_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk, .rst_n, .cs_n, .accept_i(accept_w), .mode_i(req_mode), .addr_i,
    .mode_r_i(cur_mode), .byte_end_i(byte_end_w),
    .mem_rd_o, .mem_addr_o
  );

  frd_out_drv u_out (
    .clk, .rst_n, .cs_n, .active_i(active_w), .mode_i(cur_mode),
    .dummy_i(dummy_w), .slot_i(slot_w), .mem_data_i, .status_i,
    .so_o, .so_oe_o, .sio_o, .sio_oe_o
  );

  p_fetch_lead_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && !cs_n) |=> (active_w && !dummy_w && slot_w == '0));
  p_status_no_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_w && cur_mode == RM_STATUS && !start_i) |-> !mem_rd_o);
endmodule

// File: tb/flash_rd_engine_tb.sv
`timescale 1ns/1ps
module flash_rd_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, start = 1'b0, busy = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [23:0] addr = '0;
  logic [7:0]  status = 8'hA6;
  logic        mem_rd, so, so_oe, sio, sio_oe;
  logic [23:0] mem_addr;
  logic [7:0]  mem_data = '0;
  int          n_chk = 0, n_bad = 0, rd_count = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  flash_rd_engine dut_i (
    .clk, .rst_n, .cs_n, .start_i(start), .mode_i(mode), .addr_i(addr),
    .busy_i(busy), .status_i(status), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_data_i(mem_data), .so_o(so), .so_oe_o(so_oe), .sio_o(sio), .sio_oe_o(sio_oe)
  );

  function automatic logic [7:0] pat(logic [23:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_data <= pat(mem_addr);
      rd_count <= rd_count + 1;
    end
  end

  // {mode, start address, slots}
  localparam logic [33:0] VEC [6] = '{
    {2'd0, 24'h000010, 8'd24},   // R1, R4
    {2'd1, 24'h123456, 8'd32},   // R2, R4
    {2'd2, 24'hABCDEF, 8'd24},   // R3, R4
    {2'd0, 24'hFFFFFE, 8'd32},   // R5 single
    {2'd2, 24'hFFFFFF, 8'd20},   // R5 dual
    {2'd3, 24'h000000, 8'd24}    // R6
  };

  task automatic report(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {so_oe,so,sio_oe,sio} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check_slot(input logic [1:0] m, input logic [23:0] a, input int t);
    logic [3:0] e;
    logic [7:0] b;
    logic [23:0] ba;
    int u, k;
    string tag;
    e = 4'b0000;
    tag = (m == 2'd0) ? "R1" : (m == 2'd1) ? "R2" : (m == 2'd2) ? "R3" : "R6";
    if (m == 2'd3) begin
      e = {1'b1, status[7 - (t % 8)], 2'b00};
    end else if (m == 2'd0 || t >= 8) begin
      u = (m == 2'd0) ? t : t - 8;
      k = (m == 2'd2) ? u / 4 : u / 8;
      ba = a + 24'(k);
      b = pat(ba);
      if (k > 0) tag = {tag, "/R4"};
      if (ba < a) tag = {tag, "/R5"};
      if (m == 2'd2) e = {1'b1, b[7 - 2*(u % 4)], 1'b1, b[6 - 2*(u % 4)]};
      else           e = {1'b1, b[7 - (u % 8)], 2'b00};
    end
    report($sformatf("%s slot %0d", tag, t), {so_oe, so_oe ? so : 1'b0, sio_oe, sio_oe ? sio : 1'b0}, e);
  endtask

  task automatic begin_req(input logic [1:0] m, input logic [23:0] a);
    @(negedge clk); #1;
    cs_n = 1'b0; start = 1'b1; mode = m; addr = a;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic end_req();
    @(negedge clk); #1;
    cs_n = 1'b1;
    @(posedge clk); @(posedge clk);
  endtask

  task automatic run_stream(input logic [1:0] m, input logic [23:0] a, input int slots);
    begin_req(m, a);
    for (int t = 0; t < slots; t++) begin
      @(posedge clk); #1;
      check_slot(m, a, t);
    end
    end_req();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    report("R9 reset", {so_oe, sio_oe, mem_rd, 1'b0}, 4'b0000);
    rst_n = 1'b1;
    @(posedge clk); #1;
    report("R9 after release", {so_oe, sio_oe, mem_rd, 1'b0}, 4'b0000);

    for (int i = 0; i < 6; i++)
      run_stream(VEC[i][33:32], VEC[i][31:8], int'(VEC[i][7:0]));

    // R10: plain read over 3 bytes: reads at edges 0, 8, 16, 24
    c0 = rd_count;
    run_stream(2'd0, 24'h000100, 24);
    report("R10 plain read count", 4'(rd_count - c0), 4'd4);
    // R6: status stream issues no array read
    c0 = rd_count;
    run_stream(2'd3, 24'h000000, 16);
    report("R6 status read count", 4'(rd_count - c0), 4'd0);

    // R8: busy request ignored
    c0 = rd_count;
    busy = 1'b1;
    begin_req(2'd0, 24'h000200);
    busy = 1'b0;
    for (int t = 0; t < 10; t++) begin
      @(posedge clk); #1;
      report($sformatf("R8 busy slot %0d", t), {so_oe, sio_oe, 2'b00}, 4'b0000);
    end
    report("R8 busy read count", 4'(rd_count - c0), 4'd0);
    end_req();

    // R7: cs_n rises mid-byte in a dual stream
    begin_req(2'd2, 24'h000300);
    for (int t = 0; t < 14; t++) begin
      @(posedge clk); #1;
      check_slot(2'd2, 24'h000300, t);
    end
    @(negedge clk); #1;
    cs_n = 1'b1; #1;
    report("R7 drop at cs rise", {so_oe, sio_oe, 2'b00}, 4'b0000);
    c0 = rd_count;
    for (int t = 0; t < 12; t++) begin
      @(posedge clk); #1;
      report($sformatf("R7 idle %0d", t), {so_oe, sio_oe, 2'b00}, 4'b0000);
    end
    report("R7 idle read count", 4'(rd_count - c0), 4'd0);
    // R7: clean restart after stop
    run_stream(2'd0, 24'h000040, 16);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule